// File: doc/BRIEF.md
# Fall-Through Shift-Register FIFO

This block is a first-in first-out buffer made as a chain of storage cells. Each cell holds one data word and a flag that marks it occupied. There is no RAM and there are no read or write pointers. A word that enters at the head cell moves downstream by itself, one cell per clock, whenever the next cell is free. Words therefore pile up at the output end, and free cells drift back toward the input.

Both sides use a two-phase strobe handshake on a single clock. The producer watches the load-ready status and raises the load strobe. The word on the data input is captured on that rising edge. It is held in the head cell until the strobe drops, and then it is released into the chain. The consumer watches the word-available status and raises the unload strobe to take the word. The output word stays steady while that strobe is high. The next word moves into the output cell only after the strobe falls. A synchronous active-low reset empties every cell. The default size is 4-bit words and 64 cells.

Top module: `fall_through_fifo`

## Requirements
- R1: After a synchronous active-low reset, in_ready is 1, out_ready is 0 and dout is 0.
- R2: When shift_in is sampled high at a clock edge, was sampled low at the edge before, and in_ready is 1, the word on din is captured and in_ready is 0 after that edge.
- R3: A captured word stays in the head cell while shift_in stays high, so in_ready stays 0. If the second cell is empty, in_ready returns to 1 at the second edge after the first edge at which shift_in is sampled low.
- R4: A rising shift_in while in_ready is 0 is ignored: no word is stored and the stored words are unchanged.
- R5: In an empty FIFO with shift_out low, a word loaded with shift_in high for exactly one sampled edge raises out_ready exactly DEPTH edges after the capturing edge, and dout then shows that word.
- R6: The FIFO holds exactly DEPTH words. With shift_out idle, in_ready stays 0 once DEPTH words have been accepted.
- R7: When shift_out rises while out_ready is 1, out_ready is 0 after that edge. dout does not change while shift_out stays high.
- R8: If the next word is waiting in the cell upstream of the output cell, it moves into the output cell at the second edge after the first edge at which shift_out is sampled low, and out_ready returns to 1.
- R9: A rising shift_out while out_ready is 0 is ignored: a word that arrives later still raises out_ready with no added delay and stays available.
- R10: While out_ready is 0, dout keeps its last value.
- R11: Words leave in the order in which they were accepted, for any timing of the two strobes.
- R12: In a full FIFO, when shift_out is high for one sampled edge, the free cell travels to the head and in_ready rises exactly DEPTH edges after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; empties all cells |
| shift_in | input | 1 | Load strobe; a rising edge captures din |
| din | input | WIDTH | Word to load |
| in_ready | output | 1 | Head cell is free and can accept a word |
| shift_out | input | 1 | Unload strobe; a rising edge takes the output word |
| dout | output | WIDTH | Word in the output cell |
| out_ready | output | 1 | Output cell holds a valid word |

## Verification
The bench first runs single words through an empty chain, with the load and unload strobes held for one edge and then for several. This separates the exact fall-through latency from the release timing of each handshake. A fill to capacity, followed by one extra load strobe and a single unload, checks the capacity limit and the ignored load. It also times the free cell as it bubbles back to the head. The unload strobe is raised while no word is available, to confirm that it neither blocks nor consumes a later word. Random strobe timing, alternating between fill-heavy and drain-heavy phases, is then compared against a queue model to show that no word is lost, duplicated or reordered.

// File: rtl/ftf_pkg.sv
package ftf_pkg;

    // Sampled view of one handshake strobe
    typedef struct packed {
        logic level;   // current strobe level
        logic rise;    // low-to-high transition seen this cycle
    } strobe_t;

    // Register state of the edge detector
    typedef struct packed {
        logic prev;
    } edge_state_t;

    // Register state of a handshake gate
    typedef struct packed {
        logic hold;
    } gate_state_t;

endpackage

// File: rtl/ftf_strobe.sv
module ftf_strobe
    import ftf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    level_i,
    output strobe_t evt_o
);

    edge_state_t st_d, st_q;

    always_comb begin
        st_d.prev   = level_i;
        evt_o.level = level_i;
        evt_o.rise  = level_i & ~st_q.prev;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ftf_gate.sv
module ftf_gate
    import ftf_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  strobe_t evt_i,
    input  logic    avail_i,   // the cell this side serves can act
    output logic    act_o,     // accept (load side) or take (unload side)
    output logic    hold_o     // freeze the served cell until strobe drops
);

    gate_state_t st_d, st_q;

    always_comb begin
        act_o = evt_i.rise & avail_i;
        st_d  = st_q;
        if (act_o) begin
            st_d.hold = 1'b1;
        end else if (!evt_i.level) begin
            st_d.hold = 1'b0;
        end
        hold_o = st_q.hold;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/ftf_cell.sv
module ftf_cell #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fill_i,
    input  logic [WIDTH-1:0] fill_data_i,
    input  logic             drain_i,
    output logic             valid_o,
    output logic [WIDTH-1:0] data_o
);

    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] word;
    } cell_t;

    cell_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fill_i) begin
            st_d.valid = 1'b1;
            st_d.word  = fill_data_i;
        end else if (drain_i) begin
            // the word register keeps its contents when emptied
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign data_o  = st_q.word;

endmodule

// File: rtl/ftf_chain.sv
module ftf_chain #(
    parameter int WIDTH = 4,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_data_i,
    input  logic             head_hold_i,
    input  logic             pop_i,
    input  logic             tail_hold_i,
    output logic             head_valid_o,
    output logic             tail_valid_o,
    output logic [WIDTH-1:0] tail_data_o
);

    localparam int LAST = DEPTH - 1;

    logic [LAST:0]     valid;
    logic [WIDTH-1:0]  data [DEPTH];
    logic [LAST-1:0]   advance;   // advance[j]: cell j hands its word to j+1

    for (genvar j = 0; j < LAST; j++) begin : g_adv
        localparam bit AT_HEAD = (j == 0);
        localparam bit AT_TAIL = (j == LAST - 1);
        assign advance[j] = valid[j] & ~valid[j+1]
                          & ~(AT_HEAD & head_hold_i)
                          & ~(AT_TAIL & tail_hold_i);
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_cell
        logic             fill;
        logic             drain;
        logic [WIDTH-1:0] fill_data;

        if (i == 0) begin : g_src_ext
            assign fill      = load_i;
            assign fill_data = load_data_i;
        end else begin : g_src_up
            assign fill      = advance[i-1];
            assign fill_data = data[i-1];
        end

        if (i == LAST) begin : g_snk_ext
            assign drain = pop_i;
        end else begin : g_snk_down
            assign drain = advance[i];
        end

        ftf_cell #(.WIDTH(WIDTH)) u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .fill_i      (fill),
            .fill_data_i (fill_data),
            .drain_i     (drain),
            .valid_o     (valid[i]),
            .data_o      (data[i])
        );
    end

    assign head_valid_o = valid[0];
    assign tail_valid_o = valid[LAST];
    assign tail_data_o  = data[LAST];

endmodule

// File: rtl/fall_through_fifo.sv
module fall_through_fifo
    import ftf_pkg::*;
#(
    parameter int WIDTH = 4,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_in,
    input  logic [WIDTH-1:0] din,
    output logic             in_ready,
    input  logic             shift_out,
    output logic [WIDTH-1:0] dout,
    output logic             out_ready
);

    strobe_t    load_evt;
    strobe_t    unload_evt;
    logic       head_valid;
    logic       tail_valid;
    logic       load_act;
    logic       load_hold;
    logic       pop_act;
    logic       pop_hold;

    ftf_strobe u_load_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (shift_in),
        .evt_o   (load_evt)
    );

    ftf_strobe u_unload_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (shift_out),
        .evt_o   (unload_evt)
    );

    ftf_gate u_load_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (load_evt),
        .avail_i (~head_valid),
        .act_o   (load_act),
        .hold_o  (load_hold)
    );

    ftf_gate u_unload_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .evt_i   (unload_evt),
        .avail_i (tail_valid),
        .act_o   (pop_act),
        .hold_o  (pop_hold)
    );

    ftf_chain #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chain (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load_act),
        .load_data_i  (din),
        .head_hold_i  (load_hold),
        .pop_i        (pop_act),
        .tail_hold_i  (pop_hold),
        .head_valid_o (head_valid),
        .tail_valid_o (tail_valid),
        .tail_data_o  (dout)
    );

    assign in_ready  = ~head_valid;
    assign out_ready = tail_valid;

endmodule

// File: rtl/ftf_checker.sv
module ftf_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             shift_in,
    input logic             shift_out,
    input logic             in_ready,
    input logic             out_ready,
    input logic [WIDTH-1:0] dout
);

    logic past_valid_q = 1'b0;
    logic si_prev_q;
    logic so_prev_q;
    logic load_held_q;
    logic unload_held_q;
    logic si_rise;
    logic so_rise;

    assign si_rise = shift_in & ~si_prev_q;
    assign so_rise = shift_out & ~so_prev_q;

    always_ff @(posedge clk) begin
        past_valid_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            si_prev_q     <= 1'b0;
            so_prev_q     <= 1'b0;
            load_held_q   <= 1'b0;
            unload_held_q <= 1'b0;
        end else begin
            si_prev_q <= shift_in;
            so_prev_q <= shift_out;
            if (si_rise && in_ready) begin
                load_held_q <= 1'b1;
            end else if (!shift_in) begin
                load_held_q <= 1'b0;
            end
            if (so_rise && out_ready) begin
                unload_held_q <= 1'b1;
            end else if (!shift_out) begin
                unload_held_q <= 1'b0;
            end
        end
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        (past_valid_q && $past(!rst_n) && rst_n) |-> (in_ready && !out_ready && dout == '0));

    // R2
    load_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (si_rise && in_ready) |=> !in_ready);

    // R3
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_held_q |-> !in_ready);

    // R7
    unload_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (so_rise && out_ready) |=> (!out_ready && $stable(dout)));

    // R7
    unload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid_q && unload_held_q) |-> (!out_ready && $stable(dout)));

    // R10
    empty_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid_q && !out_ready) |-> $stable(dout));

endmodule

bind fall_through_fifo ftf_checker #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_in  (shift_in),
    .shift_out (shift_out),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .dout      (dout)
);

// File: tb/fall_through_fifo_tb.sv
module fall_through_fifo_tb;

    localparam int WIDTH       = 4;
    localparam int DEPTH       = 64;
    localparam int RAND_CYCLES = 20000;
    localparam int WATCHDOG    = 150000;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             shift_in;
    logic [WIDTH-1:0] din;
    logic             in_ready;
    logic             shift_out;
    logic [WIDTH-1:0] dout;
    logic             out_ready;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;

    logic [WIDTH-1:0] q [$];

    always #2 clk = ~clk;

    fall_through_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_in  (shift_in),
        .din       (din),
        .in_ready  (in_ready),
        .shift_out (shift_out),
        .dout      (dout),
        .out_ready (out_ready)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            n_chk++;
            n_bad++;
            $display("FAIL R11 watchdog: actual %0d expected below %0d", cyc, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // take one word, checking it against the model head
    task automatic take_one(input string tag);
        int guard = 0;
        while (!out_ready && guard < 4 * DEPTH) begin
            step();
            guard++;
        end
        if (q.size() == 0) begin
            chk(1'b0, tag, 1, 0);
        end else begin
            chk(out_ready && dout == q[0], tag, int'(dout), int'(q[0]));
            void'(q.pop_front());
        end
        shift_out = 1'b1;
        step();
        shift_out = 1'b0;
        step();
    endtask

    task automatic drain_all();
        while (q.size() > 0) begin
            take_one("R11 drain order");
        end
    endtask

    initial begin
        int cnt;
        int guard;
        logic si_cur, so_cur, si_n, so_n;
        logic [WIDTH-1:0] d_n;
        int pt_si, pt_so;

        void'($urandom(32'h5eed1234));
        rst_n     = 1'b0;
        shift_in  = 1'b0;
        shift_out = 1'b0;
        din       = '0;
        repeat (3) step();
        rst_n = 1'b1;
        chk(in_ready == 1'b1, "R1 reset in_ready", int'(in_ready), 1);
        chk(out_ready == 1'b0, "R1 reset out_ready", int'(out_ready), 0);
        chk(dout == '0, "R1 reset dout", int'(dout), 0);

        // R5 latency with a one-edge load strobe; R2 and R3 release timing
        din = 4'h5;
        shift_in = 1'b1;
        step();
        chk(!in_ready, "R2 capture drops in_ready", int'(in_ready), 0);
        shift_in = 1'b0;
        cnt = 0;
        while (!out_ready && cnt < 4 * DEPTH) begin
            step();
            cnt++;
            if (cnt == 1) chk(!in_ready, "R3 in_ready low one edge after release", int'(in_ready), 0);
            if (cnt == 2) chk(in_ready, "R3 in_ready high two edges after release", int'(in_ready), 1);
        end
        chk(cnt == DEPTH, "R5 fall-through latency", cnt, DEPTH);
        chk(dout == 4'h5, "R5 word at output", int'(dout), 5);

        // R3 long hold on the load strobe
        din = 4'h9;
        shift_in = 1'b1;
        step();
        chk(!in_ready, "R2 second capture", int'(in_ready), 0);
        din = 4'h2;
        repeat (4) begin
            step();
            chk(!in_ready, "R3 held while shift_in high", int'(in_ready), 0);
        end
        shift_in = 1'b0;
        step();
        chk(!in_ready, "R3 still low at release edge", int'(in_ready), 0);
        step();
        chk(in_ready, "R3 high after release", int'(in_ready), 1);
        repeat (DEPTH + 8) step();

        // R7 unload with a long strobe, then R8 refill timing
        shift_out = 1'b1;
        step();
        chk(!out_ready && dout == 4'h5, "R7 unload drops out_ready", int'(out_ready), 0);
        repeat (3) begin
            step();
            chk(!out_ready && dout == 4'h5, "R7 word steady while shift_out high", int'(dout), 5);
        end
        shift_out = 1'b0;
        step();
        chk(!out_ready, "R8 still empty at release edge", int'(out_ready), 0);
        step();
        chk(out_ready && dout == 4'h9, "R8 next word enters", int'(dout), 9);
        shift_out = 1'b1;
        step();
        shift_out = 1'b0;
        repeat (20) step();
        chk(!out_ready && dout == 4'h9, "R10 empty keeps last word", int'(dout), 9);

        // R9 unload strobe raised while empty is ignored
        shift_out = 1'b1;
        step();
        din = 4'h3;
        shift_in = 1'b1;
        step();
        shift_in = 1'b0;
        cnt = 0;
        while (!out_ready && cnt < 4 * DEPTH) begin
            step();
            cnt++;
        end
        chk(cnt == DEPTH, "R9 latency unaffected by early unload strobe", cnt, DEPTH);
        chk(dout == 4'h3, "R9 arriving word", int'(dout), 3);
        repeat (3) step();
        chk(out_ready, "R9 word not consumed", int'(out_ready), 1);
        shift_out = 1'b0;
        step();
        q.push_back(4'h3);
        take_one("R9 word taken after new strobe");

        // R6 fill to capacity, R4 ignored load, R12 bubble travel
        for (int k = 0; k < DEPTH; k++) begin
            guard = 0;
            while (!in_ready && guard < 4 * DEPTH) begin
                step();
                guard++;
            end
            din = WIDTH'(k * 7 + 1);
            q.push_back(din);
            shift_in = 1'b1;
            step();
            shift_in = 1'b0;
            step();
        end
        repeat (2 * DEPTH) step();
        chk(!in_ready, "R6 full after DEPTH words", int'(in_ready), 0);
        chk(out_ready, "R6 output holds first word", int'(out_ready), 1);
        din = ~q[q.size() - 1];
        shift_in = 1'b1;
        step();
        shift_in = 1'b0;
        step();
        chk(!in_ready, "R4 ignored load leaves FIFO full", int'(in_ready), 0);
        chk(dout == q[0], "R11 first out after fill", int'(dout), int'(q[0]));
        void'(q.pop_front());
        shift_out = 1'b1;
        step();
        shift_out = 1'b0;
        cnt = 0;
        while (!in_ready && cnt < 4 * DEPTH) begin
            step();
            cnt++;
            if (cnt == 1) chk(!out_ready, "R8 refill not yet", int'(out_ready), 0);
            if (cnt == 2) chk(out_ready, "R8 refill after release", int'(out_ready), 1);
        end
        chk(cnt == DEPTH, "R12 bubble reaches head", cnt, DEPTH);
        drain_all();
        chk(!out_ready, "R4 no extra word after drain", int'(out_ready), 0);

        // R11 random strobe timing against the queue model
        si_cur = 1'b0;
        so_cur = 1'b0;
        for (int c = 0; c < RAND_CYCLES; c++) begin
            pt_si = (((c / 1500) % 2) == 0) ? 2 : 6;
            pt_so = (((c / 1500) % 2) == 0) ? 6 : 2;
            si_n  = (($urandom % pt_si) == 0) ? ~si_cur : si_cur;
            so_n  = (($urandom % pt_so) == 0) ? ~so_cur : so_cur;
            d_n   = WIDTH'($urandom);
            if (si_n && !si_cur && in_ready) q.push_back(d_n);
            if (so_n && !so_cur && out_ready) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R11 unexpected word", 1, 0);
                end else begin
                    chk(dout == q[0], "R11 random order", int'(dout), int'(q[0]));
                    void'(q.pop_front());
                end
            end
            shift_in  = si_n;
            shift_out = so_n;
            din       = d_n;
            si_cur    = si_n;
            so_cur    = so_n;
            step();
        end
        shift_in  = 1'b0;
        shift_out = 1'b0;
        step();
        step();
        drain_all();
        repeat (2 * DEPTH) step();
        chk(!out_ready && in_ready, "R11 empty after final drain", int'(out_ready), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule